// File: doc/BRIEF.md
# Unpipelined Divider Occupancy Tracker

This block keeps the books for an integer divider that cannot accept a new operation every cycle. An issue stage raises a divide request tagged as 32-bit or 64-bit. The tracker grants the request in the same cycle, combinationally, when the divider's occupancy allows it. It then times the operation. The divide spends three quiet cycles after issue. The divider is then busy for 32 or 64 cycles. A result-valid pulse follows, and four cycles later a pulse marks the write of the HI/LO result registers. No arithmetic happens here. The block only sequences occupancy and timing.

The busy window starts four cycles after issue. A following divide may therefore be granted up to four cycles before the current busy window closes, so the quiet lead-in of the new divide overlaps the tail of the old one. Each divide is held by one of two tracking slots. Each slot is a small state machine with the states IDLE, LEAD, BUSY, DONE, TAIL and WB. A divide is granted into the lowest idle slot. The slot moves through its states as follows:

| Transition | From | To | When |
|---|---|---|---|
| START | IDLE | LEAD | the divide is granted |
| LEAD_EXPIRE | LEAD | BUSY | after 3 cycles |
| BUSY_EXPIRE | BUSY | DONE | after 32 or 64 cycles |
| RESULT | DONE | TAIL | after 1 cycle |
| TAIL_EXPIRE | TAIL | WB | after 3 cycles |
| RETIRE | WB | IDLE | after 1 cycle |

A separate two-state gate handles multiplies. Its states are OPEN and HOLD. A granted 64-bit multiply takes the gate from OPEN to HOLD (transition BLOCK). From HOLD the gate always returns to OPEN in the next cycle (transition RELEASE). While the gate is in HOLD, no multiply may start.

Top module: `divocc_tracker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, div_grant, div_busy, div_done, div_done_is64, hilo_wr, mul_grant and mul_blocked are all 0 when no request is driven.
- R2: A 32-bit divide (div_is64=0) granted in cycle T raises div_done for exactly one cycle, T+36, with div_done_is64=0.
- R3: A 64-bit divide (div_is64=1) granted in cycle T raises div_done for exactly one cycle, T+68, with div_done_is64=1.
- R4: div_busy is 1 in cycles T+4 through T+L-1 of a divide granted in cycle T with latency L (36 or 68), and is 0 when no divide is in that window.
- R5: A divide request in cycle G is granted in the same cycle exactly when, for every divide still in flight with busy-window end E (its result cycle), E <= G+4 holds. A refused request produces no busy, done or write activity.
- R6: hilo_wr pulses for one cycle at T+L+4 for every divide granted in cycle T with latency L.
- R7: A granted 64-bit multiply (mul_is64=1) refuses any multiply request in the next cycle. mul_blocked is 1 in exactly that cycle.
- R8: A multiply request is granted in the same cycle unless the previous cycle granted a 64-bit multiply. After a granted 32-bit multiply, the next multiply is granted.
- R9: A reset applied while divides are in flight clears all busy state. No div_done or hilo_wr of those divides appears afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_req | input | 1 | Divide start request |
| div_is64 | input | 1 | Width tag of the request: 1 = 64-bit, 0 = 32-bit |
| div_grant | output | 1 | Request accepted this cycle (combinational) |
| div_busy | output | 1 | Divider is inside a busy window |
| div_done | output | 1 | One-cycle pulse: a divide result is available |
| div_done_is64 | output | 1 | Width tag of the result signalled by div_done |
| hilo_wr | output | 1 | One-cycle pulse: result registers are written |
| mul_req | input | 1 | Multiply start request |
| mul_is64 | input | 1 | Width tag of the multiply: 1 = 64-bit |
| mul_grant | output | 1 | Multiply accepted this cycle (combinational) |
| mul_blocked | output | 1 | Multiply issue is held off this cycle |

## Verification
Two pairs of events can land in the same cycle. The first pair is the start of a new divide's busy window and the result pulse of the previous divide. The second pair is a granted divide and a refused multiply. The first is provoked by holding a divide request high every cycle: the grant then falls exactly 4 cycles before the old window ends, and the bench model expects div_busy still high in the cycle div_done fires. The second is provoked by a random mix of multiply and divide requests, including 64-bit multiplies followed directly by further requests. Each cycle is judged against a bench model of issue times and latencies.

// File: rtl/divocc_pkg.sv
package divocc_pkg;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_LEAD,
        SL_BUSY,
        SL_DONE,
        SL_TAIL,
        SL_WB
    } slot_state_t;

    typedef enum logic {
        MG_OPEN,
        MG_HOLD
    } mul_state_t;

endpackage

// File: rtl/divocc_slot.sv
module divocc_slot
    import divocc_pkg::*;
#(
    parameter int LEAD_CYC   = 4,
    parameter int SHORT_BUSY = 32,
    parameter int LONG_BUSY  = 64,
    parameter int WB_DELAY   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic start_is64,
    output logic idle,
    output logic in_lead,
    output logic in_busy,
    output logic near_end,
    output logic done,
    output logic done_is64,
    output logic wb
);
    localparam int CW = $clog2(LONG_BUSY + 1);
    localparam logic [CW-1:0] LEAD_LOAD  = CW'(LEAD_CYC - 2);
    localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_BUSY - 1);
    localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_BUSY - 1);
    localparam logic [CW-1:0] TAIL_LOAD  = CW'(WB_DELAY - 2);
    localparam logic [CW-1:0] NEAR_MAX   = CW'(LEAD_CYC - 1);

    slot_state_t     st_q, st_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            wide_q, wide_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= SL_IDLE;
            cnt_q  <= '0;
            wide_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            wide_q <= wide_d;
        end
    end

    // transitions: START, LEAD_EXPIRE, BUSY_EXPIRE, RESULT, TAIL_EXPIRE, RETIRE
    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        wide_d = wide_q;
        unique case (st_q)
            SL_IDLE: begin
                if (start) begin
                    st_d   = SL_LEAD;
                    cnt_d  = LEAD_LOAD;
                    wide_d = start_is64;
                end
            end
            SL_LEAD: begin
                if (cnt_q == '0) begin
                    st_d  = SL_BUSY;
                    cnt_d = wide_q ? LONG_LOAD : SHORT_LOAD;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            SL_BUSY: begin
                if (cnt_q == '0) st_d = SL_DONE;
                else             cnt_d = cnt_q - 1'b1;
            end
            SL_DONE: begin
                st_d  = SL_TAIL;
                cnt_d = TAIL_LOAD;
            end
            SL_TAIL: begin
                if (cnt_q == '0) st_d = SL_WB;
                else             cnt_d = cnt_q - 1'b1;
            end
            SL_WB: begin
                st_d = SL_IDLE;
            end
            default: st_d = SL_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        idle      = (st_q == SL_IDLE);
        in_lead   = (st_q == SL_LEAD);
        in_busy   = (st_q == SL_BUSY);
        near_end  = in_busy && (cnt_q <= NEAR_MAX);
        done      = (st_q == SL_DONE);
        done_is64 = done && wide_q;
        wb        = (st_q == SL_WB);
    end

endmodule

// File: rtl/divocc_mulgate.sv
module divocc_mulgate
    import divocc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mul_req,
    input  logic mul_is64,
    output logic mul_grant,
    output logic mul_blocked
);
    mul_state_t st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= MG_OPEN;
        else        st_q <= st_d;
    end

    // transitions: BLOCK (OPEN->HOLD), RELEASE (HOLD->OPEN)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            MG_OPEN: if (mul_req && mul_is64) st_d = MG_HOLD;
            MG_HOLD: st_d = MG_OPEN;
            default: st_d = MG_OPEN;
        endcase
    end

    always_comb begin
        mul_blocked = (st_q == MG_HOLD);
        mul_grant   = mul_req && (st_q == MG_OPEN);
    end

endmodule

// File: rtl/divocc_tracker.sv
module divocc_tracker #(
    parameter int LEAD_CYC   = 4,
    parameter int SHORT_BUSY = 32,
    parameter int LONG_BUSY  = 64,
    parameter int WB_DELAY   = 4,
    parameter int DIV_SLOTS  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_req,
    input  logic div_is64,
    output logic div_grant,
    output logic div_busy,
    output logic div_done,
    output logic div_done_is64,
    output logic hilo_wr,
    input  logic mul_req,
    input  logic mul_is64,
    output logic mul_grant,
    output logic mul_blocked
);
    logic [DIV_SLOTS-1:0] slot_idle, slot_lead, slot_busy, slot_near;
    logic [DIV_SLOTS-1:0] slot_done, slot_d64, slot_wb, slot_start;
    logic                 allow;

    for (genvar g = 0; g < DIV_SLOTS; g++) begin : g_slot
        divocc_slot #(
            .LEAD_CYC  (LEAD_CYC),
            .SHORT_BUSY(SHORT_BUSY),
            .LONG_BUSY (LONG_BUSY),
            .WB_DELAY  (WB_DELAY)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .start     (slot_start[g]),
            .start_is64(div_is64),
            .idle      (slot_idle[g]),
            .in_lead   (slot_lead[g]),
            .in_busy   (slot_busy[g]),
            .near_end  (slot_near[g]),
            .done      (slot_done[g]),
            .done_is64 (slot_d64[g]),
            .wb        (slot_wb[g])
        );
    end

    // a new window may begin no earlier than the end of the current one
    always_comb begin
        allow     = ~(|slot_lead) && ((slot_busy & ~slot_near) == '0) && (|slot_idle);
        div_grant = div_req && allow;
    end

    // lowest idle slot takes the new divide
    always_comb begin
        logic taken;
        taken      = 1'b0;
        slot_start = '0;
        for (int i = 0; i < DIV_SLOTS; i++) begin
            if (div_grant && slot_idle[i] && !taken) begin
                slot_start[i] = 1'b1;
                taken         = 1'b1;
            end
        end
    end

    always_comb begin
        div_busy      = |slot_busy;
        div_done      = |slot_done;
        div_done_is64 = |slot_d64;
        hilo_wr       = |slot_wb;
    end

    divocc_mulgate u_mulgate (
        .clk        (clk),
        .rst_n      (rst_n),
        .mul_req    (mul_req),
        .mul_is64   (mul_is64),
        .mul_grant  (mul_grant),
        .mul_blocked(mul_blocked)
    );

endmodule

// File: rtl/divocc_checker.sv
module divocc_checker #(
    parameter int NS = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          div_req,
    input logic          div_grant,
    input logic          div_busy,
    input logic          div_done,
    input logic          mul_is64,
    input logic          mul_grant,
    input logic [NS-1:0] busy_vec,
    input logic [NS-1:0] lead_vec
);
    logic [2:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 since_rst <= '0;
        else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
    end

    // R5: no grant without a request
    assert_grant_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_grant |-> div_req);

    // R5: at most one divide inside its busy window
    assert_single_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_vec));

    // R5: at most one divide in its lead-in
    assert_single_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lead_vec));

    // R4: busy is up in the fourth cycle after a grant (window offset of 4)
    assert_busy_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd5 && $past(div_grant, 4)) |-> div_busy);

    // R2: a result follows a busy cycle
    assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 3'd2 && div_done) |-> $past(div_busy));

    // R7: a 64-bit multiply blocks the next multiply
    assert_mul_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_grant && mul_is64) |=> !mul_grant);

endmodule

bind divocc_tracker divocc_checker #(.NS(DIV_SLOTS)) u_divocc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .div_req  (div_req),
    .div_grant(div_grant),
    .div_busy (div_busy),
    .div_done (div_done),
    .mul_is64 (mul_is64),
    .mul_grant(mul_grant),
    .busy_vec (slot_busy),
    .lead_vec (slot_lead)
);

// File: tb/test_divocc_tracker.sv
`timescale 1ns/1ps
module test_divocc_tracker;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic div_req = 1'b0, div_is64 = 1'b0, mul_req = 1'b0, mul_is64 = 1'b0;
    logic div_grant, div_busy, div_done, div_done_is64, hilo_wr, mul_grant, mul_blocked;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    divocc_tracker i_divocc_tracker (
        .clk(clk), .rst_n(rst_n),
        .div_req(div_req), .div_is64(div_is64), .div_grant(div_grant),
        .div_busy(div_busy), .div_done(div_done), .div_done_is64(div_done_is64),
        .hilo_wr(hilo_wr), .mul_req(mul_req), .mul_is64(mul_is64),
        .mul_grant(mul_grant), .mul_blocked(mul_blocked)
    );

    // reference model: issue cycle and width of every divide in flight
    localparam int MSZ = 16;
    int  m_t [MSZ];
    bit  m_w [MSZ];
    bit  m_v [MSZ];
    int  cyc = 0;
    bit  m_hold = 1'b0;
    bit  last_mul64 = 1'b0;
    string phase = "";

    function automatic int lat(bit w);
        return w ? 68 : 36;
    endfunction

    function automatic bit e_grant(int c);
        for (int i = 0; i < MSZ; i++)
            if (m_v[i] && (m_t[i] + lat(m_w[i]) > c + 4)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic bit e_busy(int c);
        for (int i = 0; i < MSZ; i++)
            if (m_v[i] && c >= m_t[i] + 4 && c < m_t[i] + lat(m_w[i])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit e_done(int c);
        for (int i = 0; i < MSZ; i++)
            if (m_v[i] && c == m_t[i] + lat(m_w[i])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit e_d64(int c);
        for (int i = 0; i < MSZ; i++)
            if (m_v[i] && m_w[i] && c == m_t[i] + lat(m_w[i])) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit e_wb(int c);
        for (int i = 0; i < MSZ; i++)
            if (m_v[i] && c == m_t[i] + lat(m_w[i]) + 4) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s [%s] cycle %0d: actual %b expected %b", tag, phase, cyc, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int i = 0; i < MSZ; i++) m_v[i] = 1'b0;
        m_hold = 1'b0;
        last_mul64 = 1'b0;
    endtask

    // one cycle: drive, sample before the edge, advance the model
    task automatic step(bit dr, bit dw, bit mr, bit mw);
        bit g, mg;
        @(negedge clk);
        div_req = dr; div_is64 = dw; mul_req = mr; mul_is64 = mw;
        #1;
        g  = dr && e_grant(cyc);
        mg = mr && !m_hold;
        chk("R5 div_grant", div_grant, g);
        chk("R4 div_busy", div_busy, e_busy(cyc));
        chk(e_d64(cyc) ? "R3 div_done" : "R2 div_done", div_done, e_done(cyc));
        chk(e_d64(cyc) ? "R3 div_done_is64" : "R2 div_done_is64", div_done_is64, e_d64(cyc));
        chk("R6 hilo_wr", hilo_wr, e_wb(cyc));
        chk("R7 mul_blocked", mul_blocked, m_hold);
        if (mr) chk(m_hold ? "R7 mul_grant" : "R8 mul_grant", mul_grant, mg);
        if (g) begin
            for (int i = 0; i < MSZ; i++) begin
                if (!m_v[i]) begin
                    m_v[i] = 1'b1; m_t[i] = cyc; m_w[i] = dw;
                    break;
                end
            end
        end
        m_hold = mg && mw;
        for (int i = 0; i < MSZ; i++)
            if (m_v[i] && m_t[i] + lat(m_w[i]) + 4 < cyc + 1) m_v[i] = 1'b0;
        cyc++;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        div_req = 0; div_is64 = 0; mul_req = 0; mul_is64 = 0;
        rst_n = 1'b0;
        clear_model();
        repeat (3) @(negedge clk);
        #1;
        chk(tag, div_grant | div_busy | div_done | div_done_is64 | hilo_wr | mul_grant | mul_blocked, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D1F_5EED));
        clear_model();
        phase = "R1 reset";
        do_reset("R1 outputs in reset");
        phase = "R1 after reset";
        idle(2);

        phase = "R2 single 32-bit";
        step(1, 0, 0, 0); idle(45);
        phase = "R3 single 64-bit";
        step(1, 1, 0, 0); idle(75);

        phase = "R5 back-to-back 32-bit";
        for (int k = 0; k < 150; k++) step(1, 0, 0, 0);
        idle(45);
        phase = "R5 64 then 32 held";
        step(1, 1, 0, 0);
        for (int k = 0; k < 100; k++) step(1, 0, 0, 0);
        idle(45);

        phase = "R7 64-bit multiply pair";
        step(0, 0, 1, 1); step(0, 0, 1, 1); step(0, 0, 1, 1); step(0, 0, 1, 0);
        phase = "R8 32-bit multiply pair";
        step(0, 0, 1, 0); step(0, 0, 1, 0); step(0, 0, 1, 1); step(0, 0, 0, 0);
        phase = "R7 multiply with divide";
        step(1, 1, 1, 1); step(1, 0, 1, 0); idle(80);

        phase = "random";
        for (int k = 0; k < 2000; k++) begin
            bit dr, dw, mr, mw;
            dr = ($urandom % 8) == 0;
            dw = $urandom % 2;
            mr = ($urandom % 3) == 0;
            mw = $urandom % 2;
            step(dr, dw, mr, mw);
        end
        idle(80);

        phase = "R9 reset mid-operation";
        step(1, 1, 0, 0); idle(20);
        do_reset("R9 outputs in reset");
        cyc = 0;
        idle(90);

        finished = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule